// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block receives a two-channel serial audio stream as a slave. The bit clock, the frame clock and the serial data are all inputs. They are oversampled by a faster system clock, so the block runs entirely in the system clock domain. Each completed stereo pair is presented as two signed 32-bit words together with a one-cycle valid strobe.

A static configuration selects how the stream is decoded. The framing can be right-justified, left-justified, I2S, or a pulse-framed DSP layout with two alignment variants. The word length can be 16, 20, 24 or 32 bits. Sampling can use the rising or the falling bit-clock edge, and the frame clock can be taken at either polarity. A mixing stage after the deserializer can pass the pair through, duplicate one channel to both outputs, or drive both outputs with the channel average.

Top module: `aud_rx`

## Requirements
- R1: While reset is asserted and after its release, until the first pair completes, `valid_o` is 0 and both sample outputs are zero.
- R2: With format code 01 (left-justified) and `cfg_ws_inv_i`=0, the MSB of a word is on the first bit clock that sees the new frame clock level, and a high frame clock carries the left channel.
- R3: With format code 10 (I2S) and `cfg_ws_inv_i`=0, the MSB comes one bit clock after the frame clock level changes, and a low frame clock carries the left channel.
- R4: With format code 00 (right-justified), the LSB of a word is on the last bit clock before the frame clock changes level, whatever the half-frame length. Channel polarity is the same as in R2.
- R5: Word-length code 00/01/10/11 selects 16/20/24/32 bits. Each received word is delivered sign-extended to 32 bits.
- R6: `cfg_sck_fall_i`=0 samples `ws_i` and `sd_i` on rising bit-clock edges. A value of 1 samples them on falling edges.
- R7: Outside DSP format, `cfg_ws_inv_i`=1 swaps the frame clock level assigned to each channel.
- R8: With format code 11 (DSP), a rising frame clock marks the frame start, and the left word is followed directly by the right word. `cfg_ws_inv_i`=0 puts the left MSB one bit clock after the start clock (variant A). A value of 1 puts it on the start clock itself (variant B).
- R9: Mix code 00 passes both channels through unchanged. Code 01 drives both outputs with the left word, and code 10 drives both with the right word.
- R10: Mix code 11 drives both outputs with floor((L+R)/2), computed without overflow, including at full-scale positive and negative inputs.
- R11: `valid_o` pulses for exactly one system clock per completed stereo pair. No pulse is produced for a half-frame that was already under way when reset was released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock |
| ws_i | input | 1 | Frame clock (level in LJ/RJ/I2S formats, start pulse in DSP format) |
| sd_i | input | 1 | Serial data, MSB first |
| cfg_fmt_i | input | 2 | Framing: 00 RJ, 01 LJ, 10 I2S, 11 DSP |
| cfg_wlen_i | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| cfg_sck_fall_i | input | 1 | Sample on falling bit-clock edge when 1 |
| cfg_ws_inv_i | input | 1 | Frame clock polarity swap, or DSP variant select |
| cfg_mix_i | input | 2 | Output mix: 00 stereo, 01 left to both, 10 right to both, 11 average |
| valid_o | output | 1 | One-cycle strobe for a new output pair |
| left_o | output | 32 | Left output sample, signed |
| right_o | output | 32 | Right output sample, signed |

## Verification
The assertions rely on two input conditions. Each bit-clock level must hold for at least two system clocks, so that sampling ticks can never occur on consecutive cycles. The configuration inputs must stay constant between resets. The stimulus keeps to both. It holds each bit-clock phase for four system clocks, and changes data and frame clock only in the middle of the non-sampling phase. It applies a new configuration only while reset is asserted. Every non-DSP half-frame is 40 bit clocks long, and every DSP frame is at least one bit clock longer than two words. This leaves room for the one-clock I2S and variant-A offsets.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  localparam int unsigned SAMPLE_W = 32;
  localparam int unsigned SHIFT_W  = 2 * SAMPLE_W;
  localparam int unsigned LEN_W    = $clog2(SAMPLE_W) + 1;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    MIX_STEREO = 2'b00,
    MIX_L_BOTH = 2'b01,
    MIX_R_BOTH = 2'b10,
    MIX_AVG    = 2'b11
  } mix_e;

  typedef logic [SAMPLE_W-1:0] sample_t;

  // Number of bits in a word for a length code.
  function automatic logic [LEN_W-1:0] word_bits(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(16);
      2'b01:   return LEN_W'(20);
      2'b10:   return LEN_W'(24);
      default: return LEN_W'(32);
    endcase
  endfunction

  // Keep the low n bits of raw and extend bit n-1 upward.
  function automatic sample_t sign_fill(input sample_t raw, input logic [LEN_W-1:0] n);
    logic [LEN_W-1:0] gap;
    sample_t          up;
    gap = LEN_W'(SAMPLE_W) - n;
    up  = raw << gap;
    return sample_t'($signed(up) >>> gap);
  endfunction

  // Average with one guard bit; the shift drops the lowest bit.
  function automatic sample_t half_sum(input sample_t a, input sample_t b);
    logic signed [SAMPLE_W:0] s;
    s = $signed({a[SAMPLE_W-1], a}) + $signed({b[SAMPLE_W-1], b});
    return s[SAMPLE_W:1];
  endfunction

  // True when the given frame clock level carries the left channel.
  function automatic logic is_left(input logic [1:0] fmt, input logic lvl, input logic inv);
    return ((lvl ^ inv) == (fmt != FMT_I2S));
  endfunction
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic ws_i,
  input  logic sd_i,
  input  logic fall_i,
  output logic tick_o,
  output logic ws_o,
  output logic sd_o
);
  logic [STAGES-1:0] sck_q, ws_q, sd_q;
  logic              sck_d;
  logic              sck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '0;
      ws_q  <= '0;
      sd_q  <= '0;
      sck_d <= 1'b0;
    end else begin
      sck_q <= {sck_q[STAGES-2:0], sck_i};
      ws_q  <= {ws_q[STAGES-2:0], ws_i};
      sd_q  <= {sd_q[STAGES-2:0], sd_i};
      sck_d <= sck_q[STAGES-1];
    end
  end

  assign sck_s  = sck_q[STAGES-1];
  assign tick_o = fall_i ? (sck_d & ~sck_s) : (~sck_d & sck_s);
  assign ws_o   = ws_q[STAGES-1];
  assign sd_o   = sd_q[STAGES-1];
endmodule

// File: rtl/aud_rx_deser.sv
module aud_rx_deser
  import aud_rx_pkg::*;
#(
  parameter int unsigned POS_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       ws_i,
  input  logic       sd_i,
  input  logic [1:0] fmt_i,
  input  logic [1:0] wlen_i,
  input  logic       inv_i,
  output logic       pair_stb_o,
  output sample_t    word_l_o,
  output sample_t    word_r_o
);
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic                started, prev_ws, seen_edge, left_have;
  logic [POS_W-1:0]    pos, pos_now, pos_nxt;
  logic [LEN_W-1:0]    cnt, cnt_now, cnt_nxt;
  logic [SHIFT_W-1:0]  sh, sh_base, sh_next;
  logic [LEN_W-1:0]    nbits;
  logic [POS_W-1:0]    dsp_start, dsp_span, dsp_last;
  logic                is_dsp, lvl_edge, frame_rise, restart;
  logic                take, take_dsp, seg_done, seg_left, dsp_done;

  assign nbits      = word_bits(wlen_i);
  assign is_dsp     = (fmt_i == FMT_DSP);
  assign lvl_edge   = started && (ws_i != prev_ws);
  assign frame_rise = started && ws_i && !prev_ws;
  assign restart    = is_dsp ? frame_rise : lvl_edge;

  assign pos_now = restart ? '0 : pos;
  assign pos_nxt = (pos_now == POS_MAX) ? POS_MAX : pos_now + 1'b1;
  assign cnt_now = restart ? '0 : cnt;
  assign sh_base = restart ? '0 : sh;

  assign dsp_start = inv_i ? '0 : POS_W'(1);
  assign dsp_span  = POS_W'({nbits, 1'b0});
  assign dsp_last  = dsp_start + dsp_span - 1'b1;
  assign take_dsp  = (pos_now >= dsp_start) && (pos_now < dsp_start + dsp_span);

  always_comb begin
    case (fmt_i)
      FMT_RJ:  take = 1'b1;
      FMT_LJ:  take = (cnt_now < nbits);
      FMT_I2S: take = (pos_now != '0) && (cnt_now < nbits);
      default: take = take_dsp;
    endcase
  end

  assign sh_next  = take ? {sh_base[SHIFT_W-2:0], sd_i} : sh_base;
  assign cnt_nxt  = (take && cnt_now != '1) ? cnt_now + 1'b1 : cnt_now;
  assign seg_done = !is_dsp && lvl_edge && seen_edge;
  assign seg_left = is_left(fmt_i, prev_ws, inv_i);
  assign dsp_done = is_dsp && take_dsp && (pos_now == dsp_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started    <= 1'b0;
      prev_ws    <= 1'b0;
      seen_edge  <= 1'b0;
      left_have  <= 1'b0;
      pos        <= POS_MAX;
      cnt        <= '0;
      sh         <= '0;
      pair_stb_o <= 1'b0;
      word_l_o   <= '0;
      word_r_o   <= '0;
    end else begin
      pair_stb_o <= 1'b0;
      if (tick_i) begin
        started   <= 1'b1;
        prev_ws   <= ws_i;
        pos       <= pos_nxt;
        cnt       <= cnt_nxt;
        sh        <= sh_next;
        seen_edge <= seen_edge | lvl_edge;
        if (seg_done) begin
          if (seg_left) begin
            word_l_o  <= sign_fill(sh[SAMPLE_W-1:0], nbits);
            left_have <= 1'b1;
          end else begin
            word_r_o <= sign_fill(sh[SAMPLE_W-1:0], nbits);
            if (left_have) begin
              pair_stb_o <= 1'b1;
              left_have  <= 1'b0;
            end
          end
        end
        if (dsp_done) begin
          word_l_o   <= sign_fill(sample_t'(sh_next >> nbits), nbits);
          word_r_o   <= sign_fill(sh_next[SAMPLE_W-1:0], nbits);
          pair_stb_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/aud_rx_mix.sv
module aud_rx_mix
  import aud_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_i,
  input  sample_t    l_i,
  input  sample_t    r_i,
  input  logic [1:0] mix_i,
  output logic       valid_o,
  output sample_t    left_o,
  output sample_t    right_o
);
  sample_t ml, mr, avg;

  assign avg = half_sum(l_i, r_i);

  always_comb begin
    case (mix_e'(mix_i))
      MIX_L_BOTH: begin ml = l_i; mr = l_i; end
      MIX_R_BOTH: begin ml = r_i; mr = r_i; end
      MIX_AVG:    begin ml = avg; mr = avg; end
      default:    begin ml = l_i; mr = r_i; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      left_o  <= '0;
      right_o <= '0;
    end else begin
      valid_o <= stb_i;
      if (stb_i) begin
        left_o  <= ml;
        right_o <= mr;
      end
    end
  end
endmodule

// File: rtl/aud_rx.sv
module aud_rx
  import aud_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned POS_W       = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        ws_i,
  input  logic        sd_i,
  input  logic [1:0]  cfg_fmt_i,
  input  logic [1:0]  cfg_wlen_i,
  input  logic        cfg_sck_fall_i,
  input  logic        cfg_ws_inv_i,
  input  logic [1:0]  cfg_mix_i,
  output logic        valid_o,
  output logic [31:0] left_o,
  output logic [31:0] right_o
);
  logic    samp_tick, samp_ws, samp_sd;
  logic    pair_stb;
  sample_t word_l, word_r;

  aud_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .ws_i(ws_i), .sd_i(sd_i),
    .fall_i(cfg_sck_fall_i), .tick_o(samp_tick), .ws_o(samp_ws), .sd_o(samp_sd)
  );

  aud_rx_deser #(.POS_W(POS_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .tick_i(samp_tick), .ws_i(samp_ws), .sd_i(samp_sd),
    .fmt_i(cfg_fmt_i), .wlen_i(cfg_wlen_i), .inv_i(cfg_ws_inv_i),
    .pair_stb_o(pair_stb), .word_l_o(word_l), .word_r_o(word_r)
  );

  aud_rx_mix u_mix (
    .clk(clk), .rst_n(rst_n), .stb_i(pair_stb), .l_i(word_l), .r_i(word_r),
    .mix_i(cfg_mix_i), .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
  );
endmodule

// File: rtl/aud_rx_chk.sv
module aud_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        samp_tick,
  input logic        pair_stb,
  input logic        valid_o,
  input logic [31:0] left_o,
  input logic [31:0] right_o,
  input logic [1:0]  cfg_mix_i,
  input logic [1:0]  cfg_wlen_i
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r11_stb_from_tick: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |-> $past(samp_tick));

  a_r11_stb_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb |=> valid_o);

  a_r9_left_both: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_mix_i == 2'b01) |-> (left_o == right_o));

  a_r9_right_both: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_mix_i == 2'b10) |-> (left_o == right_o));

  a_r10_avg_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_mix_i == 2'b11) |-> (left_o == right_o));

  a_r5_sext16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && cfg_wlen_i == 2'b00 && cfg_mix_i == 2'b00)
      |-> ((left_o[31:15] == '0 || left_o[31:15] == '1) &&
           (right_o[31:15] == '0 || right_o[31:15] == '1)));

  a_r1_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !$past(valid_o)) |-> ($stable(left_o) && $stable(right_o)));
endmodule

bind aud_rx aud_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .pair_stb(pair_stb),
  .valid_o(valid_o), .left_o(left_o), .right_o(right_o),
  .cfg_mix_i(cfg_mix_i), .cfg_wlen_i(cfg_wlen_i)
);

// File: tb/aud_rx_tb.sv
module aud_rx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_LEN   = 40;
  localparam int MAXF       = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, ws = 1'b0, sd = 1'b0;
  logic [1:0] fmt = 2'b01, wlen = 2'b00, mix = 2'b00;
  logic fall = 1'b0, inv = 1'b0;
  logic valid_o;
  logic [31:0] left_o, right_o;

  int n_checks = 0, n_fail = 0, ncap = 0;
  logic [31:0] cap_l [MAXF], cap_r [MAXF];
  logic [31:0] src_l [MAXF], src_r [MAXF];

  always #(CLK_PERIOD/2) clk = ~clk;

  aud_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .ws_i(ws), .sd_i(sd),
    .cfg_fmt_i(fmt), .cfg_wlen_i(wlen), .cfg_sck_fall_i(fall),
    .cfg_ws_inv_i(inv), .cfg_mix_i(mix),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o)
  );

  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (ncap < MAXF) begin
        cap_l[ncap] = left_o;
        cap_r[ncap] = right_o;
      end
      ncap++;
    end
  end

  task automatic check32(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic int bits_of(input logic [1:0] c);
    return (c == 2'b11) ? 32 : 16 + 4 * int'(c);
  endfunction

  function automatic longint to_signed(input logic [31:0] v, input int n);
    longint x;
    x = longint'(v) & ((64'sd1 <<< n) - 1);
    if (x >= (64'sd1 <<< (n - 1))) x = x - (64'sd1 <<< n);
    return x;
  endfunction

  task automatic bclk(input logic w, input logic d);
    sck = fall;
    repeat (2) @(negedge clk);
    ws = w;
    sd = d;
    repeat (2) @(negedge clk);
    sck = ~fall;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_half(input logic lvl, input logic [31:0] word, input int n);
    for (int p = 0; p < HALF_LEN; p++) begin
      logic b;
      b = 1'b1;
      if (fmt == 2'b01 && p < n) b = word[n-1-p];
      if (fmt == 2'b10 && p >= 1 && p <= n) b = word[n-p];
      if (fmt == 2'b00 && p >= HALF_LEN - n) b = word[HALF_LEN-1-p];
      bclk(lvl, b);
    end
  endtask

  task automatic send_dsp(input logic [31:0] lw, input logic [31:0] rw, input int n);
    int s;
    s = inv ? 0 : 1;
    for (int p = 0; p < 2 * n + 4; p++) begin
      logic b;
      b = 1'b1;
      if (p >= s && p < s + n) b = lw[n-1-(p-s)];
      else if (p >= s + n && p < s + 2 * n) b = rw[n-1-(p-s-n)];
      bclk(p == 0, b);
    end
  endtask

  task automatic apply_cfg(input logic [1:0] f, input logic [1:0] w, input logic fe,
                           input logic iv, input logic [1:0] m);
    rst_n = 1'b0;
    fmt = f; wlen = w; fall = fe; inv = iv; mix = m;
    sck = fe; ws = 1'b0; sd = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    ncap = 0;
  endtask

  // One scenario: frames with generated words, then compare every output pair.
  task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] w,
                          input logic fe, input logic iv, input logic [1:0] m,
                          input int seed, input bit extreme);
    int n;
    logic lvl_l;
    apply_cfg(f, w, fe, iv, m);
    n = bits_of(w);
    for (int i = 0; i < 3; i++) begin
      if (extreme) begin
        src_l[i] = (i == 1) ? 32'h8000_0000 : 32'h7FFF_FFFF;
        src_r[i] = (i == 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
        src_l[i] = src_l[i] >> (32 - n);
        src_r[i] = src_r[i] >> (32 - n);
      end else begin
        src_l[i] = (32'h9E37_79B9 * (seed * 8 + i + 1)) ^ 32'h5A5A_1234;
        src_r[i] = (32'h85EB_CA6B * (seed * 8 + i + 3)) ^ 32'h0F0F_A5C3;
      end
    end
    if (f == 2'b11) begin
      repeat (3) bclk(1'b0, 1'b1);
      for (int i = 0; i < 3; i++) send_dsp(src_l[i], src_r[i], n);
      repeat (3) bclk(1'b0, 1'b1);
    end else begin
      lvl_l = ((f == 2'b10) ? 1'b0 : 1'b1) ^ iv;
      send_half(~lvl_l, 32'h0, n);
      for (int i = 0; i < 3; i++) begin
        send_half(lvl_l, src_l[i], n);
        send_half(~lvl_l, src_r[i], n);
      end
      send_half(lvl_l, 32'h0, n);
    end
    repeat (10) @(negedge clk);
    check32({tag, " R11 pair count"}, 32'(ncap), 32'd3);
    for (int i = 0; i < 3 && i < ncap; i++) begin
      longint a, b, el, er;
      a = to_signed(src_l[i], n);
      b = to_signed(src_r[i], n);
      case (m)
        2'b01:   begin el = a; er = a; end
        2'b10:   begin el = b; er = b; end
        2'b11:   begin el = (a + b) >>> 1; er = el; end
        default: begin el = a; er = b; end
      endcase
      check32({tag, " left"},  cap_l[i], el[31:0]);
      check32({tag, " right"}, cap_r[i], er[31:0]);
    end
  endtask

  task automatic test_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check32("R1 valid in reset", {31'b0, valid_o}, 32'd0);
    check32("R1 left in reset", left_o, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check32("R1 valid after reset", {31'b0, valid_o}, 32'd0);
    check32("R1 right after reset", right_o, 32'd0);
  endtask

  initial begin
    test_reset();
    run_case("R2 R5 LJ 16",            2'b01, 2'b00, 1'b0, 1'b0, 2'b00, 1, 1'b0);
    run_case("R3 I2S 24",              2'b10, 2'b10, 1'b0, 1'b0, 2'b00, 2, 1'b0);
    run_case("R4 R5 RJ 20",            2'b00, 2'b01, 1'b0, 1'b0, 2'b00, 3, 1'b0);
    run_case("R6 LJ 32 falling",       2'b01, 2'b11, 1'b1, 1'b0, 2'b00, 4, 1'b0);
    run_case("R7 I2S 16 ws inverted",  2'b10, 2'b00, 1'b0, 1'b1, 2'b00, 5, 1'b0);
    run_case("R7 RJ 24 ws inverted",   2'b00, 2'b10, 1'b1, 1'b1, 2'b00, 6, 1'b0);
    run_case("R8 DSP A 24",            2'b11, 2'b10, 1'b0, 1'b0, 2'b00, 7, 1'b0);
    run_case("R8 DSP B 16",            2'b11, 2'b00, 1'b0, 1'b1, 2'b00, 8, 1'b0);
    run_case("R9 mix left",            2'b01, 2'b00, 1'b0, 1'b0, 2'b01, 9, 1'b0);
    run_case("R9 mix right",           2'b10, 2'b01, 1'b0, 1'b0, 2'b10, 10, 1'b0);
    run_case("R10 avg extremes 32",    2'b10, 2'b11, 1'b0, 1'b0, 2'b11, 11, 1'b1);
    run_case("R10 avg DSP 20",         2'b11, 2'b01, 1'b1, 1'b0, 2'b11, 12, 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule